// File: doc/BRIEF.md
# UART Automatic Flow Controller

This block decides when serial traffic should pause or resume on one UART channel. It has no FIFO storage and no serial shifting of its own. It watches the fill level of the receive FIFO and the stream of characters coming out of the deserializer. It drives the outgoing RTS line, a transmit-permit signal for the transmit engine, and a one-character insertion request for sending flow-control characters.

Two programmable fill levels control pausing. The halt level stops the remote sender and the resume level restarts it. The same pair serves hardware flow control, which drops RTS, and software flow control, which inserts XOFF and XON characters. On the transmit side, an inactive CTS or a received XOFF withdraws the transmit permit. The transmit engine samples that permit only when it is about to start a new character, so a character already being shifted out always completes. An option lets any received character lift a stop caused by XOFF.

All outputs are registered. A change on any input shows at the outputs after exactly one rising clock edge. Reset is synchronous and active-high.

Top module: `uart_flow_ctrl`

## Requirements
- R1: After reset, rts_active=1, tx_allow=1, ins_req=0 and rx_wr_en=0.
- R2: With cfg_auto_rts=1, rts_active goes to 0 one cycle after rxf_level >= cfg_halt_lvl. It returns to 1 only one cycle after rxf_level <= cfg_resume_lvl (and below the halt level). In between, it keeps its previous value. With cfg_auto_rts=0, rts_active is 1.
- R3: With cfg_auto_cts=1, tx_allow is 0 one cycle after cts_active=0 and returns to 1 one cycle after cts_active=1. With cfg_auto_cts=0, cts_active has no effect on tx_allow.
- R4: With cfg_sw_tx_en=1, the first cycle in which rxf_level >= cfg_halt_lvl raises ins_req with ins_char=cfg_xoff_char on the next cycle. Staying above the halt level raises no further request.
- R5: After such a halt, the first cycle in which rxf_level <= cfg_resume_lvl raises ins_req with ins_char=cfg_xon_char on the next cycle, once per crossing.
- R6: ins_req stays 1 until a cycle with ins_ack=1, and is 0 on the cycle after that acknowledge unless a new crossing occurred.
- R7: With cfg_sw_rx_en=1, a received character equal to cfg_xoff_char is not forwarded (rx_wr_en=0 the next cycle) and sets tx_allow to 0 on the next cycle.
- R8: With cfg_sw_rx_en=1, a received character equal to cfg_xon_char (and different from cfg_xoff_char) is not forwarded and restores tx_allow to 1 on the next cycle, provided CTS does not block.
- R9: With cfg_any_resume=1, any other received character also clears a stop caused by XOFF and is forwarded with rx_wr_en=1. With cfg_any_resume=0, such a character is forwarded and the stop stays.
- R10: With cfg_sw_rx_en=0, every received character is forwarded unchanged one cycle later, and XOFF characters do not affect tx_allow.
- R11: Fill levels and thresholds are 7-bit values from 0 to 64, and a single halt/resume pair governs both RTS and XON/XOFF insertion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_auto_rts | input | 1 | Enable RTS control from the fill level |
| cfg_auto_cts | input | 1 | Enable transmit hold from CTS |
| cfg_sw_tx_en | input | 1 | Enable XOFF/XON insertion |
| cfg_sw_rx_en | input | 1 | Enable detection of received XOFF/XON |
| cfg_any_resume | input | 1 | Any received character lifts an XOFF stop |
| cfg_halt_lvl | input | 7 | Fill level that halts the remote sender |
| cfg_resume_lvl | input | 7 | Fill level that resumes the remote sender |
| cfg_xon_char | input | 8 | XON character value |
| cfg_xoff_char | input | 8 | XOFF character value |
| rxf_level | input | 7 | Current receive FIFO fill level |
| cts_active | input | 1 | CTS asserted (1 = remote ready) |
| rts_active | output | 1 | RTS asserted (1 = ready to receive) |
| tx_allow | output | 1 | Transmit engine may start the next data character |
| ins_req | output | 1 | Request to insert a flow-control character |
| ins_char | output | 8 | Character to insert |
| ins_ack | input | 1 | Transmit engine has taken the inserted character |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | 8 | Received character |
| rx_wr_en | output | 1 | Write strobe toward the receive FIFO |
| rx_wr_data | output | 8 | Character written to the receive FIFO |

## Verification
The bench builds the block with its default depth of 64 and 8-bit characters. With that depth, both an empty FIFO (level 0) and a full one (level 64) can be driven as fill levels. It uses a halt level of 48 and a resume level of 16. This leaves a wide band in which the bench can show that RTS holds its value in both directions. The XON and XOFF values are set away from the usual control codes. This shows that the programmed values, not fixed ones, are compared and inserted.

// File: rtl/fc_pkg.sv
package fc_pkg;

    localparam int unsigned FC_DEPTH  = 64;
    localparam int unsigned FC_CHAR_W = 8;

    typedef enum logic {
        FLOW_RUN  = 1'b0,
        FLOW_HALT = 1'b1
    } flow_state_e;

    typedef struct packed {
        logic                 req;
        logic [FC_CHAR_W-1:0] ch;
    } ins_slot_t;

    typedef struct packed {
        logic stop;
        logic wr_en;
    } rx_decision_t;

    // Level compare helpers; thresholds use the same width as the level.
    function automatic logic lvl_reached(input logic [6:0] lvl, input logic [6:0] thr);
        return lvl >= thr;
    endfunction

    function automatic logic lvl_drained(input logic [6:0] lvl, input logic [6:0] thr);
        return lvl <= thr;
    endfunction

endpackage

// File: rtl/fc_hyst.sv
module fc_hyst
    import fc_pkg::*;
#(
    parameter int unsigned LVL_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] halt_lvl,
    input  logic [LVL_W-1:0] resume_lvl,
    output logic             halted,
    output logic             halt_evt,
    output logic             resume_evt
);

    flow_state_e state_q;
    logic        at_halt;
    logic        at_resume;

    always_comb begin
        at_halt    = lvl_reached(7'(level), 7'(halt_lvl));
        at_resume  = lvl_drained(7'(level), 7'(resume_lvl)) && !at_halt;
        halt_evt   = en && (state_q == FLOW_RUN)  && at_halt;
        resume_evt = en && (state_q == FLOW_HALT) && at_resume;
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state_q <= FLOW_RUN;
        end else if (halt_evt) begin
            state_q <= FLOW_HALT;
        end else if (resume_evt) begin
            state_q <= FLOW_RUN;
        end
    end

    assign halted = (state_q == FLOW_HALT);

endmodule

// File: rtl/fc_insert.sv
module fc_insert
    import fc_pkg::*;
#(
    parameter int unsigned CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              halt_evt,
    input  logic              resume_evt,
    input  logic [CHAR_W-1:0] xon_char,
    input  logic [CHAR_W-1:0] xoff_char,
    input  logic              ack,
    output logic              req,
    output logic [CHAR_W-1:0] ch
);

    ins_slot_t slot_q;
    ins_slot_t slot_d;

    always_comb begin
        slot_d = slot_q;
        if (ack) begin
            slot_d.req = 1'b0;
        end
        if (halt_evt) begin
            slot_d.req = 1'b1;
            slot_d.ch  = xoff_char;
        end else if (resume_evt) begin
            slot_d.req = 1'b1;
            slot_d.ch  = xon_char;
        end
        if (!en) begin
            slot_d.req = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign req = slot_q.req;
    assign ch  = slot_q.ch;

endmodule

// File: rtl/fc_rx_filter.sv
module fc_rx_filter
    import fc_pkg::*;
#(
    parameter int unsigned CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              any_resume,
    input  logic [CHAR_W-1:0] xon_char,
    input  logic [CHAR_W-1:0] xoff_char,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_data,
    output logic              stop_nxt,
    output logic              wr_en,
    output logic [CHAR_W-1:0] wr_data
);

    logic         stop_q;
    logic         is_xoff;
    logic         is_xon;
    rx_decision_t dec;

    always_comb begin
        is_xoff   = en && (rx_data == xoff_char);
        is_xon    = en && (rx_data == xon_char) && !is_xoff;
        dec.stop  = stop_q;
        dec.wr_en = rx_valid && !is_xoff && !is_xon;
        if (!en) begin
            dec.stop = 1'b0;
        end else if (rx_valid) begin
            if (is_xoff) begin
                dec.stop = 1'b1;
            end else if (is_xon || any_resume) begin
                dec.stop = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stop_q  <= 1'b0;
            wr_en   <= 1'b0;
            wr_data <= '0;
        end else begin
            stop_q  <= dec.stop;
            wr_en   <= dec.wr_en;
            wr_data <= rx_data;
        end
    end

    assign stop_nxt = dec.stop;

endmodule

// File: rtl/uart_flow_ctrl.sv
module uart_flow_ctrl
    import fc_pkg::*;
#(
    parameter int unsigned DEPTH  = FC_DEPTH,
    parameter int unsigned CHAR_W = FC_CHAR_W,
    localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_auto_rts,
    input  logic              cfg_auto_cts,
    input  logic              cfg_sw_tx_en,
    input  logic              cfg_sw_rx_en,
    input  logic              cfg_any_resume,
    input  logic [LVL_W-1:0]  cfg_halt_lvl,
    input  logic [LVL_W-1:0]  cfg_resume_lvl,
    input  logic [CHAR_W-1:0] cfg_xon_char,
    input  logic [CHAR_W-1:0] cfg_xoff_char,
    input  logic [LVL_W-1:0]  rxf_level,
    input  logic              cts_active,
    output logic              rts_active,
    output logic              tx_allow,
    output logic              ins_req,
    output logic [CHAR_W-1:0] ins_char,
    input  logic              ins_ack,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_data,
    output logic              rx_wr_en,
    output logic [CHAR_W-1:0] rx_wr_data
);

    logic rts_halted, rts_halt_evt, rts_resume_evt;
    logic sw_halted, sw_halt_evt, sw_resume_evt;
    logic remote_stop_nxt;
    logic allow_q;

    // Hardware path: RTS hysteresis on the shared threshold pair
    fc_hyst #(.LVL_W(LVL_W)) u_rts_hyst (
        .clk        (clk),
        .rst        (rst),
        .en         (cfg_auto_rts),
        .level      (rxf_level),
        .halt_lvl   (cfg_halt_lvl),
        .resume_lvl (cfg_resume_lvl),
        .halted     (rts_halted),
        .halt_evt   (rts_halt_evt),
        .resume_evt (rts_resume_evt)
    );

    // Software path: same thresholds, tracked separately
    fc_hyst #(.LVL_W(LVL_W)) u_sw_hyst (
        .clk        (clk),
        .rst        (rst),
        .en         (cfg_sw_tx_en),
        .level      (rxf_level),
        .halt_lvl   (cfg_halt_lvl),
        .resume_lvl (cfg_resume_lvl),
        .halted     (sw_halted),
        .halt_evt   (sw_halt_evt),
        .resume_evt (sw_resume_evt)
    );

    fc_insert #(.CHAR_W(CHAR_W)) u_insert (
        .clk        (clk),
        .rst        (rst),
        .en         (cfg_sw_tx_en),
        .halt_evt   (sw_halt_evt),
        .resume_evt (sw_resume_evt),
        .xon_char   (cfg_xon_char),
        .xoff_char  (cfg_xoff_char),
        .ack        (ins_ack),
        .req        (ins_req),
        .ch         (ins_char)
    );

    fc_rx_filter #(.CHAR_W(CHAR_W)) u_rx_filter (
        .clk        (clk),
        .rst        (rst),
        .en         (cfg_sw_rx_en),
        .any_resume (cfg_any_resume),
        .xon_char   (cfg_xon_char),
        .xoff_char  (cfg_xoff_char),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .stop_nxt   (remote_stop_nxt),
        .wr_en      (rx_wr_en),
        .wr_data    (rx_wr_data)
    );

    // Transmit permit: sampled by the engine only at character start,
    // so a character in flight always completes.
    always_ff @(posedge clk) begin
        if (rst) begin
            allow_q <= 1'b1;
        end else begin
            allow_q <= !(cfg_auto_cts && !cts_active) && !remote_stop_nxt;
        end
    end

    assign tx_allow   = allow_q;
    assign rts_active = !rts_halted;

endmodule

// File: rtl/fc_checker.sv
module fc_checker #(
    parameter int unsigned LVL_W  = 7,
    parameter int unsigned CHAR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_auto_rts,
    input logic              cfg_auto_cts,
    input logic              cfg_sw_rx_en,
    input logic [LVL_W-1:0]  cfg_halt_lvl,
    input logic [LVL_W-1:0]  cfg_resume_lvl,
    input logic [CHAR_W-1:0] cfg_xon_char,
    input logic [CHAR_W-1:0] cfg_xoff_char,
    input logic [LVL_W-1:0]  rxf_level,
    input logic              cts_active,
    input logic              rts_active,
    input logic              tx_allow,
    input logic              ins_req,
    input logic              ins_ack,
    input logic              rx_valid,
    input logic [CHAR_W-1:0] rx_data,
    input logic              rx_wr_en,
    input logic [CHAR_W-1:0] rx_wr_data
);

    AST_RTS_HALT: assert property (@(posedge clk) disable iff (rst)
        cfg_auto_rts && (rxf_level >= cfg_halt_lvl) |=> !rts_active); // R2

    AST_RTS_RESUME: assert property (@(posedge clk) disable iff (rst)
        cfg_auto_rts && (rxf_level <= cfg_resume_lvl) && (rxf_level < cfg_halt_lvl)
        |=> rts_active); // R2

    AST_RTS_MANUAL: assert property (@(posedge clk) disable iff (rst)
        !cfg_auto_rts |=> rts_active); // R2

    AST_CTS_BLOCK: assert property (@(posedge clk) disable iff (rst)
        cfg_auto_cts && !cts_active |=> !tx_allow); // R3

    AST_INS_HOLD: assert property (@(posedge clk) disable iff (rst)
        ins_req && !ins_ack |=> ins_req); // R6

    AST_XOFF_EATEN: assert property (@(posedge clk) disable iff (rst)
        cfg_sw_rx_en && rx_valid && (rx_data == cfg_xoff_char)
        |=> !rx_wr_en && !tx_allow); // R7

    AST_XON_EATEN: assert property (@(posedge clk) disable iff (rst)
        cfg_sw_rx_en && rx_valid && (rx_data == cfg_xon_char)
        && (rx_data != cfg_xoff_char) && cts_active
        |=> !rx_wr_en && tx_allow); // R8

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
        !cfg_sw_rx_en && rx_valid |=> rx_wr_en && (rx_wr_data == $past(rx_data))); // R10

    AST_NO_SPURIOUS_WR: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |=> !rx_wr_en); // R10

endmodule

bind uart_flow_ctrl fc_checker #(.LVL_W(LVL_W), .CHAR_W(CHAR_W)) u_fc_checker (
    .clk            (clk),
    .rst            (rst),
    .cfg_auto_rts   (cfg_auto_rts),
    .cfg_auto_cts   (cfg_auto_cts),
    .cfg_sw_rx_en   (cfg_sw_rx_en),
    .cfg_halt_lvl   (cfg_halt_lvl),
    .cfg_resume_lvl (cfg_resume_lvl),
    .cfg_xon_char   (cfg_xon_char),
    .cfg_xoff_char  (cfg_xoff_char),
    .rxf_level      (rxf_level),
    .cts_active     (cts_active),
    .rts_active     (rts_active),
    .tx_allow       (tx_allow),
    .ins_req        (ins_req),
    .ins_ack        (ins_ack),
    .rx_valid       (rx_valid),
    .rx_data        (rx_data),
    .rx_wr_en       (rx_wr_en),
    .rx_wr_data     (rx_wr_data)
);

// File: tb/tb_uart_flow_ctrl.sv
`timescale 1ns/1ps
module tb_uart_flow_ctrl;

    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_auto_rts, cfg_auto_cts, cfg_sw_tx_en, cfg_sw_rx_en, cfg_any_resume;
    logic [6:0] cfg_halt_lvl, cfg_resume_lvl, rxf_level;
    logic [7:0] cfg_xon_char, cfg_xoff_char;
    logic       cts_active, rts_active, tx_allow, ins_req, ins_ack, rx_valid, rx_wr_en;
    logic [7:0] ins_char, rx_data, rx_wr_data;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    uart_flow_ctrl dut (
        .clk(clk), .rst(rst),
        .cfg_auto_rts(cfg_auto_rts), .cfg_auto_cts(cfg_auto_cts),
        .cfg_sw_tx_en(cfg_sw_tx_en), .cfg_sw_rx_en(cfg_sw_rx_en),
        .cfg_any_resume(cfg_any_resume),
        .cfg_halt_lvl(cfg_halt_lvl), .cfg_resume_lvl(cfg_resume_lvl),
        .cfg_xon_char(cfg_xon_char), .cfg_xoff_char(cfg_xoff_char),
        .rxf_level(rxf_level), .cts_active(cts_active),
        .rts_active(rts_active), .tx_allow(tx_allow),
        .ins_req(ins_req), .ins_char(ins_char), .ins_ack(ins_ack),
        .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_wr_en(rx_wr_en), .rx_wr_data(rx_wr_data)
    );

    // {expected rts_active, fill level}; halt=48, resume=16 (R2, R11)
    localparam logic [7:0] RTS_VEC [10] = '{
        {1'b1, 7'd0},  {1'b1, 7'd20}, {1'b1, 7'd47}, {1'b0, 7'd48}, {1'b0, 7'd30},
        {1'b0, 7'd17}, {1'b1, 7'd16}, {1'b1, 7'd40}, {1'b0, 7'd64}, {1'b1, 7'd0}
    };

    localparam logic [7:0] XON_V  = 8'hA1;
    localparam logic [7:0] XOFF_V = 8'hB3;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive at a falling edge, results visible at the next falling edge
    task automatic tick();
        @(negedge clk);
    endtask

    task automatic send_rx(input logic [7:0] d);
        rx_valid = 1'b1;
        rx_data  = d;
        tick();
        rx_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        rst = 1'b1;
        cfg_auto_rts = 0; cfg_auto_cts = 0; cfg_sw_tx_en = 0; cfg_sw_rx_en = 0;
        cfg_any_resume = 0;
        cfg_halt_lvl = 7'd48; cfg_resume_lvl = 7'd16;
        cfg_xon_char = XON_V; cfg_xoff_char = XOFF_V;
        rxf_level = 0; cts_active = 1; ins_ack = 0; rx_valid = 0; rx_data = 0;
        repeat (3) tick();

        // R1 reset state
        chk("R1 rts", rts_active, 1);
        chk("R1 allow", tx_allow, 1);
        chk("R1 ins_req", ins_req, 0);
        chk("R1 wr_en", rx_wr_en, 0);
        rst = 1'b0;
        tick();

        // R2 hysteresis walk, table driven
        cfg_auto_rts = 1'b1;
        for (int i = 0; i < 10; i++) begin
            rxf_level = RTS_VEC[i][6:0];
            tick();
            chk($sformatf("R2 vec%0d", i), rts_active, RTS_VEC[i][7]);
        end
        // R2 disabled: full level keeps RTS asserted
        cfg_auto_rts = 1'b0; rxf_level = 7'd64; tick();
        chk("R2 disabled", rts_active, 1);
        rxf_level = 0; tick();

        // R3 auto-CTS
        cfg_auto_cts = 1'b1; cts_active = 1'b0; tick();
        chk("R3 cts low", tx_allow, 0);
        cts_active = 1'b1; tick();
        chk("R3 cts high", tx_allow, 1);
        cfg_auto_cts = 1'b0; cts_active = 1'b0; tick();
        chk("R3 ignored", tx_allow, 1);
        cts_active = 1'b1;

        // R4/R5/R6 software insertion, shared thresholds (R11)
        cfg_sw_tx_en = 1'b1; rxf_level = 7'd50; tick();
        chk("R4 xoff req", ins_req, 1);
        chk("R4 xoff char", ins_char, XOFF_V);
        chk("R11 rts untouched", rts_active, 1);
        tick(); tick();
        chk("R6 held", ins_req, 1);
        ins_ack = 1'b1; tick(); ins_ack = 1'b0;
        chk("R6 cleared", ins_req, 0);
        rxf_level = 7'd60; tick(); tick();
        chk("R4 once", ins_req, 0);
        rxf_level = 7'd30; tick();
        chk("R5 band", ins_req, 0);
        rxf_level = 7'd16; tick();
        chk("R5 xon req", ins_req, 1);
        chk("R5 xon char", ins_char, XON_V);
        ins_ack = 1'b1; tick(); ins_ack = 1'b0;
        rxf_level = 7'd5; tick();
        chk("R5 once", ins_req, 0);
        cfg_sw_tx_en = 1'b0; rxf_level = 0; tick();

        // R7/R8/R9 received flow characters
        cfg_sw_rx_en = 1'b1;
        send_rx(XOFF_V);
        chk("R7 not written", rx_wr_en, 0);
        chk("R7 stopped", tx_allow, 0);
        send_rx(8'h41);
        chk("R9 off written", rx_wr_en, 1);
        chk("R9 off still stopped", tx_allow, 0);
        send_rx(XON_V);
        chk("R8 not written", rx_wr_en, 0);
        chk("R8 resumed", tx_allow, 1);
        cfg_any_resume = 1'b1;
        send_rx(XOFF_V);
        chk("R7 stop again", tx_allow, 0);
        send_rx(8'h55);
        chk("R9 any resumes", tx_allow, 1);
        chk("R9 written", rx_wr_en, 1);
        chk("R9 data", rx_wr_data, 8'h55);
        cfg_any_resume = 1'b0;

        // R10 detection disabled
        cfg_sw_rx_en = 1'b0;
        send_rx(XOFF_V);
        chk("R10 written", rx_wr_en, 1);
        chk("R10 data", rx_wr_data, XOFF_V);
        chk("R10 no stop", tx_allow, 1);
        tick();
        chk("R10 strobe ends", rx_wr_en, 0);

        done = 1'b1;
        finish_run();
    end

endmodule